// File: doc/BRIEF.md
# Landing-Pad Expected-State Tracker

This block holds the single "landing pad expected" bit of a hart. The retire logic raises it after an indirect jump when landing-pad checking is enabled for the current mode, and lowers it once a landing pad has been reached. The bit must survive interruptions of control flow. Four entry paths each copy it into a saved bit of their own and then clear it: an ordinary trap into M, S/HS or VS, a resumable non-maskable interrupt, and Debug Mode entry. On the matching return, the saved bit is copied back, but only if landing-pad checking is enabled in the mode being returned to. Otherwise the live bit returns cleared.

The enable for a mode is taken from the security-configuration and environment-configuration enable inputs. The privilege encoding is U=0, S=1, M=3. A build parameter states whether supervisor mode exists. The saved bits are exposed so that status registers can show them, and they can be written through a simple CSR write port.

Top module: `lp_state_tracker`

## Requirements
- R1: A synchronous active-low reset clears the live bit and every saved bit, and the NMI status word reads 0. Reset overrides all strobes.
- R2: Outside entry and return cycles, `lp_arm` sets the live bit when the enable of the current mode (`cur_prv`, `cur_virt`) is 1, and otherwise leaves it unchanged. `lp_done` clears the live bit. If both are raised, `lp_arm` wins.
- R3: With supervisor mode present, the enable of a mode is chosen as follows: M uses `en_msec`; S with virt=0 uses `en_menv`; S with virt=1 uses `en_henv`; U uses `en_senv` regardless of virt. The reserved privilege value 2 has enable 0.
- R4: A trap copies the live bit into one saved bit and clears the live bit. A target of S with `trap_virt`=1 selects `vs_saved_elp`, S with `trap_virt`=0 selects `s_saved_elp`, and any other target selects `m_saved_elp`. The other saved bits keep their values.
- R5: A return uses `ret_kind` 0 for M-return and 1 for S-return. M-return reads `m_saved_elp`. S-return reads `vs_saved_elp` when `cur_virt`=1 and `s_saved_elp` otherwise. The live bit takes the value read if the enable of mode (`ret_prv`, `ret_virt`) is 1, and becomes 0 otherwise. The saved bit that was read is cleared.
- R6: Debug entry copies the live bit into `dbg_saved_elp` and clears the live bit. Debug resume (`ret_kind`=3) restores the live bit from `dbg_saved_elp` under the R5 gating rule and leaves `dbg_saved_elp` unchanged.
- R7: NMI entry copies the live bit into bit 9 of `nmi_status` and clears the live bit. All other bits of `nmi_status` are 0. NMI return (`ret_kind`=2) restores the live bit under the R5 gating rule and leaves the saved bit unchanged.
- R8: At most one event acts in a cycle. The priority is debug entry, then NMI entry, then trap, then return, then `lp_arm`/`lp_done`. Events that lose are ignored entirely.
- R9: `csr_we` writes `csr_wdata` into the saved bit chosen by `csr_sel`: 0 selects M, 1 selects S, 2 selects VS, 3 selects NMI and 4 selects debug. Values 5 to 7 write nothing. The write is dropped in any cycle that carries an entry strobe or `ret_valid`.
- R10: With `HAS_SMODE`=0, M uses `en_msec` and every other privilege value uses `en_menv`. Traps that target S go to `m_saved_elp`. `s_saved_elp` and `vs_saved_elp` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_prv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Current virtualization state |
| en_msec | input | 1 | M-mode landing-pad enable (security configuration) |
| en_menv | input | 1 | Machine env-config landing-pad enable |
| en_henv | input | 1 | Hypervisor env-config landing-pad enable |
| en_senv | input | 1 | Supervisor env-config landing-pad enable |
| lp_arm | input | 1 | Indirect jump retired: expect a landing pad |
| lp_done | input | 1 | Landing pad reached |
| trap_valid | input | 1 | Trap taken this cycle |
| trap_prv | input | 2 | Trap target privilege |
| trap_virt | input | 1 | Trap target is virtualized (VS) |
| nmi_entry | input | 1 | Resumable NMI taken |
| dbg_entry | input | 1 | Debug Mode entered |
| ret_valid | input | 1 | Return executed this cycle |
| ret_kind | input | 2 | 0 M-return, 1 S-return, 2 NMI return, 3 debug resume |
| ret_prv | input | 2 | Privilege being returned to |
| ret_virt | input | 1 | Virtualization being returned to |
| csr_we | input | 1 | Saved-bit write strobe |
| csr_sel | input | 3 | Saved-bit select |
| csr_wdata | input | 1 | Saved-bit write value |
| elp | output | 1 | Live landing-pad-expected bit |
| m_saved_elp | output | 1 | Saved bit for M traps |
| s_saved_elp | output | 1 | Saved bit for S/HS traps |
| vs_saved_elp | output | 1 | Saved bit for VS traps |
| nmi_status | output | 16 | NMI status word, saved bit at bit 9 |
| dbg_saved_elp | output | 1 | Saved bit for Debug Mode |

## Verification
A trap and a return can fall in the same cycle. A CSR write can also coincide with an entry or a return. Directed cycles raise these strobes together after the live and saved bits have been preloaded with distinct values. The check then confirms that the trap's save happened and that the return's restore and clear did not. A dropped write is confirmed by the unchanged saved output. Random stimulus also raises overlapping strobes, and a bench model that applies the stated priority judges every such cycle.

// File: rtl/lp_pkg.sv
// Shared encodings for the landing-pad state tracker.
// Assumes privilege encoding U=0, S=1, M=3 (value 2 reserved).
package lp_pkg;
    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    // Saved-bit bank indices; equal to the CSR select codes.
    localparam int BK_M   = 0;
    localparam int BK_S   = 1;
    localparam int BK_VS  = 2;
    localparam int BK_NMI = 3;
    localparam int BK_DBG = 4;
    localparam int NBANK  = 5;

    // NMI status word layout.
    localparam int NMS_W        = 16;
    localparam int NMS_PELP_BIT = 9;

    typedef enum logic [1:0] {
        RET_M   = 2'd0,
        RET_S   = 2'd1,
        RET_NMI = 2'd2,
        RET_DBG = 2'd3
    } ret_kind_e;
endpackage

// File: rtl/lp_enable_sel.sv
// Landing-pad enable lookup for one (privilege, virt) pair.
// Purely combinational. HAS_SMODE picks the mapping variant.
// Assumes privilege encoding from lp_pkg; value 2 is reserved.
module lp_enable_sel #(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [1:0] prv,
    input  logic       virt,
    input  logic       en_msec,
    input  logic       en_menv,
    input  logic       en_henv,
    input  logic       en_senv,
    output logic       en
);
    import lp_pkg::*;

    generate
        if (HAS_SMODE) begin : g_with_s
            // Four-mode mapping with virtualization split at S.
            always_comb begin
                unique case (prv)
                    PRV_M:   en = en_msec;
                    PRV_S:   en = virt ? en_henv : en_menv;
                    PRV_U:   en = en_senv;
                    default: en = 1'b0;
                endcase
            end
        end else begin : g_no_s
            // Two-mode mapping: M versus everything else.
            logic unused_ok;
            assign unused_ok = virt ^ en_henv ^ en_senv;
            assign en = (prv == PRV_M) ? en_msec : en_menv;
        end
    endgenerate
endmodule

// File: rtl/lp_save_bank.sv
// Bank of saved landing-pad bits, one per entry path.
// Each bit is loaded from the live bit on save, cleared on return,
// or written from the CSR port; the decoder guarantees one action per bit.
// Bits whose path is absent (IMPL clear) read constant 0.
module lp_save_bank #(
    parameter int              NB   = 5,
    parameter logic [NB-1:0]   IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] save_v,
    input  logic [NB-1:0] clr_v,
    input  logic [NB-1:0] wr_v,
    input  logic          elp,
    input  logic          wdata,
    output logic [NB-1:0] saved
);
    generate
        for (genvar gi = 0; gi < NB; gi++) begin : g_bit
            if (IMPL[gi]) begin : g_impl
                // Per-bit storage with save > clear > write ordering.
                always_ff @(posedge clk) begin
                    if (!rst_n)           saved[gi] <= 1'b0;
                    else if (save_v[gi])  saved[gi] <= elp;
                    else if (clr_v[gi])   saved[gi] <= 1'b0;
                    else if (wr_v[gi])    saved[gi] <= wdata;
                end

                p_save_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    save_v[gi] |=> saved[gi] == $past(elp));
                p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    !(save_v[gi] || clr_v[gi] || wr_v[gi]) |=> $stable(saved[gi]));
            end else begin : g_tied
                assign saved[gi] = 1'b0;
            end
        end
    endgenerate

    p_one_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(save_v));
endmodule

// File: rtl/lp_state_tracker.sv
// Landing-pad expected-state tracker (top).
// Holds the live ELP bit and decodes trap, NMI, debug, return and CSR
// strobes into one action per cycle. The priority is debug > NMI > trap >
// return > arm/done. All outputs are registered; effects appear one clock
// after the strobe. Assumes at most one return kind per cycle.
module lp_state_tracker #(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cur_prv,
    input  logic                     cur_virt,
    input  logic                     en_msec,
    input  logic                     en_menv,
    input  logic                     en_henv,
    input  logic                     en_senv,
    input  logic                     lp_arm,
    input  logic                     lp_done,
    input  logic                     trap_valid,
    input  logic [1:0]               trap_prv,
    input  logic                     trap_virt,
    input  logic                     nmi_entry,
    input  logic                     dbg_entry,
    input  logic                     ret_valid,
    input  logic [1:0]               ret_kind,
    input  logic [1:0]               ret_prv,
    input  logic                     ret_virt,
    input  logic                     csr_we,
    input  logic [2:0]               csr_sel,
    input  logic                     csr_wdata,
    output logic                     elp,
    output logic                     m_saved_elp,
    output logic                     s_saved_elp,
    output logic                     vs_saved_elp,
    output logic [lp_pkg::NMS_W-1:0] nmi_status,
    output logic                     dbg_saved_elp
);
    import lp_pkg::*;

    localparam int            NB     = NBANK;
    localparam logic [NB-1:0] S_MASK = (NB'(1) << BK_S) | (NB'(1) << BK_VS);
    localparam logic [NB-1:0] IMPL   = HAS_SMODE ? '1 : ~S_MASK;

    logic          cur_en, ret_en;
    logic          any_entry, do_ret;
    logic [2:0]    ret_bk;
    logic          src_bit;
    logic [NB-1:0] save_v, clr_v, wr_v, saved;
    logic          elp_q, elp_d;

    lp_enable_sel #(.HAS_SMODE(HAS_SMODE)) u_en_cur (
        .prv(cur_prv), .virt(cur_virt),
        .en_msec(en_msec), .en_menv(en_menv), .en_henv(en_henv), .en_senv(en_senv),
        .en(cur_en)
    );

    lp_enable_sel #(.HAS_SMODE(HAS_SMODE)) u_en_ret (
        .prv(ret_prv), .virt(ret_virt),
        .en_msec(en_msec), .en_menv(en_menv), .en_henv(en_henv), .en_senv(en_senv),
        .en(ret_en)
    );

    // Event decode: pick the single acting event and steer the bank.
    always_comb begin
        any_entry = trap_valid || nmi_entry || dbg_entry;
        do_ret    = ret_valid && !any_entry;

        save_v = '0;
        if (dbg_entry)                                   save_v[BK_DBG] = 1'b1;
        else if (nmi_entry)                              save_v[BK_NMI] = 1'b1;
        else if (trap_valid) begin
            if (HAS_SMODE && trap_prv == PRV_S)          save_v[trap_virt ? BK_VS : BK_S] = 1'b1;
            else                                         save_v[BK_M] = 1'b1;
        end

        unique case (ret_kind)
            RET_M:   ret_bk = 3'(BK_M);
            RET_S:   ret_bk = cur_virt ? 3'(BK_VS) : 3'(BK_S);
            RET_NMI: ret_bk = 3'(BK_NMI);
            default: ret_bk = 3'(BK_DBG);
        endcase
        src_bit = saved[ret_bk];

        clr_v = '0;
        if (do_ret && (ret_kind == RET_M || ret_kind == RET_S)) clr_v[ret_bk] = 1'b1;

        wr_v = '0;
        if (csr_we && !any_entry && !ret_valid && csr_sel <= 3'(BK_DBG)) wr_v[csr_sel] = 1'b1;
    end

    // Next value of the live bit.
    always_comb begin
        if (any_entry)                 elp_d = 1'b0;
        else if (do_ret)               elp_d = ret_en & src_bit;
        else if (lp_arm && cur_en)     elp_d = 1'b1;
        else if (lp_done)              elp_d = 1'b0;
        else                           elp_d = elp_q;
    end

    // Live bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) elp_q <= 1'b0;
        else        elp_q <= elp_d;
    end

    lp_save_bank #(.NB(NB), .IMPL(IMPL)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .save_v(save_v), .clr_v(clr_v), .wr_v(wr_v),
        .elp(elp_q), .wdata(csr_wdata), .saved(saved)
    );

    // Output views of the stored state.
    always_comb begin
        elp           = elp_q;
        m_saved_elp   = saved[BK_M];
        s_saved_elp   = saved[BK_S];
        vs_saved_elp  = saved[BK_VS];
        dbg_saved_elp = saved[BK_DBG];
        nmi_status    = '0;
        nmi_status[NMS_PELP_BIT] = saved[BK_NMI];
    end

    p_entry_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid || nmi_entry || dbg_entry) |=> !elp);
    p_ret_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !any_entry && !ret_en) |=> !elp);
    p_mret_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !any_entry && ret_kind == RET_M) |=> !m_saved_elp);
    p_dbg_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry |=> dbg_saved_elp == $past(elp));
    p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_entry && !ret_valid && lp_arm && cur_en) |=> elp);
endmodule

// File: tb/lp_state_tracker_tb.sv
// Bench: directed corners plus seeded random stimulus, checked each cycle
// against a behavioural model built from the requirements. Two instances:
// u_dut (supervisor mode present) and u_dut_nos (absent, R10).
module lp_state_tracker_tb;
    import lp_pkg::*;

    localparam int CLK_PERIOD  = 10;
    localparam int RAND_CYCLES = 4000;
    localparam int WD_LIMIT    = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] cur_prv, trap_prv, ret_prv, ret_kind;
    logic cur_virt, en_msec, en_menv, en_henv, en_senv;
    logic lp_arm, lp_done, trap_valid, trap_virt, nmi_entry, dbg_entry;
    logic ret_valid, ret_virt, csr_we, csr_wdata;
    logic [2:0] csr_sel;

    logic             o_elp[2], o_m[2], o_s[2], o_vs[2], o_dbg[2];
    logic [NMS_W-1:0] o_nmi[2];

    bit e_elp[2], e_m[2], e_s[2], e_vs[2], e_nmi[2], e_dbg[2];
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_state_tracker #(.HAS_SMODE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cur_prv(cur_prv), .cur_virt(cur_virt),
        .en_msec(en_msec), .en_menv(en_menv), .en_henv(en_henv), .en_senv(en_senv),
        .lp_arm(lp_arm), .lp_done(lp_done), .trap_valid(trap_valid), .trap_prv(trap_prv),
        .trap_virt(trap_virt), .nmi_entry(nmi_entry), .dbg_entry(dbg_entry),
        .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_prv(ret_prv), .ret_virt(ret_virt),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .elp(o_elp[0]), .m_saved_elp(o_m[0]), .s_saved_elp(o_s[0]),
        .vs_saved_elp(o_vs[0]), .nmi_status(o_nmi[0]), .dbg_saved_elp(o_dbg[0])
    );

    lp_state_tracker #(.HAS_SMODE(1'b0)) u_dut_nos (
        .clk(clk), .rst_n(rst_n), .cur_prv(cur_prv), .cur_virt(cur_virt),
        .en_msec(en_msec), .en_menv(en_menv), .en_henv(en_henv), .en_senv(en_senv),
        .lp_arm(lp_arm), .lp_done(lp_done), .trap_valid(trap_valid), .trap_prv(trap_prv),
        .trap_virt(trap_virt), .nmi_entry(nmi_entry), .dbg_entry(dbg_entry),
        .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_prv(ret_prv), .ret_virt(ret_virt),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .elp(o_elp[1]), .m_saved_elp(o_m[1]), .s_saved_elp(o_s[1]),
        .vs_saved_elp(o_vs[1]), .nmi_status(o_nmi[1]), .dbg_saved_elp(o_dbg[1])
    );

    // Enable of a mode per R3 / R10.
    function automatic bit lpe(bit has_s, logic [1:0] prv, logic virt);
        if (prv == PRV_M) return en_msec;
        if (!has_s)       return en_menv;
        if (prv == PRV_S) return virt ? en_henv : en_menv;
        if (prv == PRV_U) return en_senv;
        return 1'b0;
    endfunction

    // One clock of the reference model for instance k.
    task automatic model_step(int k, bit has_s);
        bit src, en;
        if (!rst_n) begin
            e_elp[k] = 0; e_m[k] = 0; e_s[k] = 0; e_vs[k] = 0; e_nmi[k] = 0; e_dbg[k] = 0;
        end else if (dbg_entry) begin
            e_dbg[k] = e_elp[k]; e_elp[k] = 0;
        end else if (nmi_entry) begin
            e_nmi[k] = e_elp[k]; e_elp[k] = 0;
        end else if (trap_valid) begin
            if (has_s && trap_prv == PRV_S) begin
                if (trap_virt) e_vs[k] = e_elp[k]; else e_s[k] = e_elp[k];
            end else e_m[k] = e_elp[k];
            e_elp[k] = 0;
        end else if (ret_valid) begin
            en = lpe(has_s, ret_prv, ret_virt);
            case (ret_kind)
                2'd0: begin src = e_m[k]; e_m[k] = 0; end
                2'd1: begin
                    if (cur_virt) begin src = e_vs[k]; e_vs[k] = 0; end
                    else          begin src = e_s[k];  e_s[k]  = 0; end
                end
                2'd2: src = e_nmi[k];
                default: src = e_dbg[k];
            endcase
            e_elp[k] = en & src;
        end else begin
            if (lp_arm && lpe(has_s, cur_prv, cur_virt)) e_elp[k] = 1;
            else if (lp_done)                            e_elp[k] = 0;
            if (csr_we) begin
                case (csr_sel)
                    3'd0: e_m[k] = csr_wdata;
                    3'd1: if (has_s) e_s[k] = csr_wdata;
                    3'd2: if (has_s) e_vs[k] = csr_wdata;
                    3'd3: e_nmi[k] = csr_wdata;
                    3'd4: e_dbg[k] = csr_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string req);
        for (int k = 0; k < 2; k++) begin
            logic [NMS_W-1:0] v;
            string r10;
            v = '0;
            v[NMS_PELP_BIT] = e_nmi[k];
            r10 = (k == 1) ? {req, "/R10"} : req;
            chk(r10, "elp", 16'(o_elp[k]), 16'(e_elp[k]));
            chk(r10, "m_saved", 16'(o_m[k]), 16'(e_m[k]));
            chk(r10, "s_saved", 16'(o_s[k]), 16'(e_s[k]));
            chk(r10, "vs_saved", 16'(o_vs[k]), 16'(e_vs[k]));
            chk(r10, "nmi_status(R7)", 16'(o_nmi[k]), 16'(v));
            chk(r10, "dbg_saved", 16'(o_dbg[k]), 16'(e_dbg[k]));
        end
    endtask

    function automatic string pick_tag();
        int n;
        n = int'(dbg_entry) + int'(nmi_entry) + int'(trap_valid) + int'(ret_valid);
        if (!rst_n)       return "R1";
        if (n > 1 || (n == 1 && (csr_we || lp_arm))) return "R8";
        if (dbg_entry)    return "R6";
        if (nmi_entry)    return "R7";
        if (trap_valid)   return "R4";
        if (ret_valid)    return (ret_kind == 2'd3) ? "R6" : (ret_kind == 2'd2) ? "R7" : "R5";
        if (csr_we)       return "R9";
        return "R2";
    endfunction

    // Apply current inputs for one clock and compare after the edge.
    task automatic cycle(string req = "");
        tag = (req == "") ? pick_tag() : req;
        model_step(0, 1'b1);
        model_step(1, 1'b0);
        @(posedge clk);
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        lp_arm = 0; lp_done = 0; trap_valid = 0; nmi_entry = 0; dbg_entry = 0;
        ret_valid = 0; csr_we = 0; trap_prv = PRV_M; trap_virt = 0;
        ret_kind = 2'd0; ret_prv = PRV_U; ret_virt = 0; csr_sel = 3'd0; csr_wdata = 0;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        cur_prv = PRV_M; cur_virt = 0;
        en_msec = 1; en_menv = 1; en_henv = 1; en_senv = 1;
        rst_n = 0;
        @(negedge clk);
        lp_arm = 1; csr_we = 1; csr_wdata = 1; // R1: reset overrides strobes
        cycle("R1");
        cycle("R1");
        idle();
        rst_n = 1;
        cycle("R1");

        // R3 / R10: every enable pattern against every mode.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 2; v++) begin
                    {en_msec, en_menv, en_henv, en_senv} = 4'(c);
                    cur_prv = 2'(p); cur_virt = 1'(v);
                    lp_arm = 1; cycle("R3");
                    lp_arm = 0; lp_done = 1; cycle("R2");
                    lp_done = 0;
                end
            end
        end

        // R8: trap and M-return together; trap wins, M saved bit kept.
        {en_msec, en_menv, en_henv, en_senv} = 4'hF;
        cur_prv = PRV_M; cur_virt = 0;
        lp_arm = 1; cycle("R2");
        lp_arm = 0; trap_valid = 1; trap_prv = PRV_M; cycle("R4");
        lp_arm = 1; trap_valid = 0; cycle("R2");
        trap_valid = 1; trap_prv = PRV_S; trap_virt = 0;
        ret_valid = 1; ret_kind = 2'd0; ret_prv = PRV_M; lp_arm = 0;
        cycle("R8");
        idle();
        // R9: CSR write dropped under a return, then accepted alone.
        csr_we = 1; csr_sel = 3'd4; csr_wdata = 1; ret_valid = 1; ret_kind = 2'd3;
        cycle("R9");
        ret_valid = 0; cycle("R9");
        csr_sel = 3'd6; csr_wdata = 0; cycle("R9");
        // R7: NMI save then gated return.
        idle(); lp_arm = 1; cycle("R2");
        lp_arm = 0; nmi_entry = 1; cycle("R7");
        nmi_entry = 0; en_senv = 0; ret_valid = 1; ret_kind = 2'd2; ret_prv = PRV_U; cycle("R7");
        en_senv = 1; cycle("R7");
        idle();

        // Random phase.
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            r = $urandom_range(0, 2);
            cur_prv   = (r == 0) ? PRV_U : (r == 1) ? PRV_S : PRV_M;
            cur_virt  = 1'($urandom_range(0, 1));
            {en_msec, en_menv, en_henv, en_senv} = 4'($urandom_range(0, 15));
            lp_arm     = ($urandom_range(0, 99) < 30);
            lp_done    = ($urandom_range(0, 99) < 20);
            trap_valid = ($urandom_range(0, 99) < 10);
            trap_prv   = 2'($urandom_range(0, 3));
            trap_virt  = 1'($urandom_range(0, 1));
            nmi_entry  = ($urandom_range(0, 99) < 4);
            dbg_entry  = ($urandom_range(0, 99) < 4);
            ret_valid  = ($urandom_range(0, 99) < 15);
            ret_kind   = 2'($urandom_range(0, 3));
            ret_prv    = 2'($urandom_range(0, 3));
            ret_virt   = 1'($urandom_range(0, 1));
            csr_we     = ($urandom_range(0, 99) < 15);
            csr_sel    = 3'($urandom_range(0, 7));
            csr_wdata  = 1'($urandom_range(0, 1));
            cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule